// File: doc/BRIEF.md
# Per-Lane Receive Sampling Delay Calibrator

This controller picks the sampling delay for every serial data lane of a multi-lane receiver. Each lane feeds an external fine-step delay line whose tap setting comes from this block. On a start command the block sweeps every tap value from 0 to 31. All lanes share the sweep tap while it runs. At each tap it waits for the delay line to settle and then asks the sender to restart its training sequence. Each lane then checks the bits it receives against that sequence.

The training sequence has four parts: idle zeros, a single one-cycle high sync bit, a fixed gap of zero bits, and a repeating pattern word. Each lane aligns on its own sync bit. A tap passes for a lane only if the lane sees the full gap and then a fixed number of pattern bits with no error. Taps are 75 ps each, so a data eye of about 2.3 ns spans roughly 30 taps, and the 32-tap sweep covers it. The sweep does not depend on the lane bit rate, so the block works across the 160 MHz to 240 MHz range.

When the sweep ends, each lane takes the tap at the middle of its longest unbroken run of passing taps. It then reports success, or it reports failure if no tap passed. The host reads the final per-lane taps and the status flags from the output ports.

Top module: `laneDelayCal`

## Requirements
- R1: After reset, `busy`, `senderReset`, `laneDone` and `laneFail` are 0 and every lane tap is 0.
- R2: A `start` pulse while idle raises `busy` on the next cycle. During the sweep, every lane's tap equals the shared sweep tap, which starts at 0 and only ever steps up by one, up to 31.
- R3: After the tap changes, `senderReset` is not raised until the tap has been held for at least SETTLE_CYC (8) further cycles.
- R4: `senderReset` is a one-cycle pulse, issued exactly once per tap, so there are 32 pulses per sweep.
- R5: A tap passes for a lane only if, within the measurement window after the pulse, the lane sees a 1 (the sync bit), then SYNC_GAP (4) zeros, then SAMPLES (256) bits that all equal PATTERN (8'hB4). The pattern bits are compared least-significant bit first and repeat every 8 bits. A lane whose input never shows the sync bit fails that tap.
- R6: When the sweep ends, a lane with at least one passing tap takes tap start + (length-1)/2 of its longest run of consecutive passing taps. If two runs tie, the lower one wins. The lane's `laneDone` bit goes to 1.
- R7: A lane with no passing tap sets its `laneFail` bit and clears its `laneDone` bit, and its tap is driven to 0.
- R8: `busy` falls when the sweep ends. At that point every lane has exactly one of `laneDone` and `laneFail` set.
- R9: A `start` pulse while `busy` is high is ignored, and the sweep continues from its current tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that starts a calibration sweep |
| laneBits | input | LANES | Sampled bit of each lane after its delay line |
| busy | output | 1 | High while a sweep is in progress |
| senderReset | output | 1 | One-cycle request for the sender to restart its training sequence |
| tapOut | output | LANES*TAP_W | Tap value per lane; lane n uses bits [n*TAP_W +: TAP_W] |
| laneDone | output | LANES | Lane found a passing window and holds its centred tap |
| laneFail | output | LANES | Lane found no passing tap |

## Verification
The hardest case to reach from the ports is a lane whose best window is not its only window. Examples are two runs of equal length, or a longer run that starts late. Another hard case is a tap that fails because the sync bit never arrives, as opposed to one that fails on mismatched bits. The bench models the delay line as a pass mask for each lane. Taps inside the mask return the clean training stream with a different sync delay per lane. Taps outside the mask return random bits. Directed masks set up ties, windows at both ends of the range, a single-tap window, an empty mask and a lane that stays silent, and seeded random masks with one or two windows fill in the rest.

// File: rtl/calib_pkg.sv
package calib_pkg;

  typedef enum logic [2:0] {
    CAL_IDLE,
    CAL_SETTLE,
    CAL_KICK,
    CAL_MEASURE,
    CAL_JUDGE,
    CAL_FINISH
  } calState_e;

  typedef enum logic [1:0] {
    PH_HUNT,
    PH_GAP,
    PH_CMP,
    PH_FIN
  } lanePhase_e;

  // strobes from the sequencer to the per-lane datapath
  typedef struct packed {
    logic clrAll;    // new sweep: forget all results
    logic startTap;  // training restarted: lanes re-arm their comparators
    logic judge;     // measurement over: fold pass/fail into run tracker
    logic finish;    // sweep over: pick centre tap
  } calStrobe_t;

endpackage

// File: rtl/calCtrl.sv
module calCtrl
  import calib_pkg::*;
#(
  parameter int TAP_W      = 5,
  parameter int SETTLE_CYC = 8,
  parameter int MEAS_LIMIT = 294
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             allMeasDone,
  output calStrobe_t       strobe,
  output logic [TAP_W-1:0] sweepTap,
  output logic             busy,
  output logic             senderReset
);

  localparam int CNT_MAX = (MEAS_LIMIT > SETTLE_CYC) ? MEAS_LIMIT : SETTLE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [TAP_W-1:0] TAP_LAST = '1;

  calState_e        state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= CAL_IDLE;
      cnt      <= '0;
      sweepTap <= '0;
    end else begin
      unique case (state)
        CAL_IDLE: begin
          if (start) begin
            state    <= CAL_SETTLE;
            sweepTap <= '0;
            cnt      <= '0;
          end
        end
        CAL_SETTLE: begin
          if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
            state <= CAL_KICK;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        CAL_KICK: begin
          state <= CAL_MEASURE;
          cnt   <= '0;
        end
        CAL_MEASURE: begin
          if (allMeasDone || cnt == CNT_W'(MEAS_LIMIT - 1)) begin
            state <= CAL_JUDGE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        CAL_JUDGE: begin
          cnt <= '0;
          if (sweepTap == TAP_LAST) begin
            state <= CAL_FINISH;
          end else begin
            sweepTap <= sweepTap + 1'b1;
            state    <= CAL_SETTLE;
          end
        end
        CAL_FINISH: state <= CAL_IDLE;
        default:    state <= CAL_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clrAll   = (state == CAL_IDLE) && start;
    strobe.startTap = (state == CAL_KICK);
    strobe.judge    = (state == CAL_JUDGE);
    strobe.finish   = (state == CAL_FINISH);
    busy            = (state != CAL_IDLE);
    senderReset     = (state == CAL_KICK);
  end

endmodule

// File: rtl/calDatapath.sv
module calDatapath
  import calib_pkg::*;
#(
  parameter int                  LANES    = 4,
  parameter int                  TAP_W    = 5,
  parameter int                  SAMPLES  = 256,
  parameter int                  SYNC_GAP = 4,
  parameter int                  PAT_LEN  = 8,
  parameter logic [PAT_LEN-1:0]  PATTERN  = 8'hB4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  calStrobe_t             strobe,
  input  logic [TAP_W-1:0]       sweepTap,
  input  logic                   busy,
  input  logic [LANES-1:0]       laneBits,
  output logic [LANES*TAP_W-1:0] tapOut,
  output logic [LANES-1:0]       laneDone,
  output logic [LANES-1:0]       laneFail,
  output logic                   allMeasDone
);

  localparam int GAP_W = $clog2(SYNC_GAP + 1);
  localparam int SMP_W = $clog2(SAMPLES + 1);
  localparam int PI_W  = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
  localparam int LEN_W = TAP_W + 1;

  logic [LANES-1:0] measDone;
  assign allMeasDone = &measDone;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    lanePhase_e       phase;
    logic [GAP_W-1:0] gapCnt;
    logic [SMP_W-1:0] smpCnt;
    logic [PI_W-1:0]  patIdx;
    logic             errSeen;
    logic             doneL;
    logic             okL;
    logic             failL;
    logic [TAP_W-1:0] curStart, bestStart, chosen, runStart;
    logic [LEN_W-1:0] curLen, bestLen, runLen, centre;
    logic             tapPass;
    logic             bitIn;

    assign bitIn = laneBits[g];

    // training-sequence comparator
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        phase   <= PH_FIN;
        gapCnt  <= '0;
        smpCnt  <= '0;
        patIdx  <= '0;
        errSeen <= 1'b0;
        doneL   <= 1'b0;
      end else if (strobe.startTap) begin
        phase   <= PH_HUNT;
        gapCnt  <= '0;
        smpCnt  <= '0;
        patIdx  <= '0;
        errSeen <= 1'b0;
        doneL   <= 1'b0;
      end else begin
        unique case (phase)
          PH_HUNT: begin
            if (bitIn) begin
              phase  <= PH_GAP;
              gapCnt <= '0;
            end
          end
          PH_GAP: begin
            if (bitIn) errSeen <= 1'b1;
            if (gapCnt == GAP_W'(SYNC_GAP - 1)) begin
              phase  <= PH_CMP;
              patIdx <= '0;
              smpCnt <= '0;
            end else begin
              gapCnt <= gapCnt + 1'b1;
            end
          end
          PH_CMP: begin
            if (bitIn != PATTERN[patIdx]) errSeen <= 1'b1;
            patIdx <= (patIdx == PI_W'(PAT_LEN - 1)) ? '0 : patIdx + 1'b1;
            if (smpCnt == SMP_W'(SAMPLES - 1)) begin
              phase <= PH_FIN;
              doneL <= 1'b1;
            end else begin
              smpCnt <= smpCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end

    assign measDone[g] = doneL;

    always_comb begin
      tapPass  = doneL && !errSeen;
      runLen   = curLen + 1'b1;
      runStart = (curLen == '0) ? sweepTap : curStart;
      centre   = {1'b0, bestStart} + ((bestLen - 1'b1) >> 1);
    end

    // longest-run tracker and centre selection
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        curStart  <= '0;
        curLen    <= '0;
        bestStart <= '0;
        bestLen   <= '0;
        chosen    <= '0;
        okL       <= 1'b0;
        failL     <= 1'b0;
      end else if (strobe.clrAll) begin
        curStart  <= '0;
        curLen    <= '0;
        bestStart <= '0;
        bestLen   <= '0;
        chosen    <= '0;
        okL       <= 1'b0;
        failL     <= 1'b0;
      end else if (strobe.judge) begin
        if (tapPass) begin
          curLen   <= runLen;
          curStart <= runStart;
          if (runLen > bestLen) begin
            bestLen   <= runLen;
            bestStart <= runStart;
          end
        end else begin
          curLen <= '0;
        end
      end else if (strobe.finish) begin
        if (bestLen == '0) begin
          chosen <= '0;
          failL  <= 1'b1;
          okL    <= 1'b0;
        end else begin
          chosen <= centre[TAP_W-1:0];
          okL    <= 1'b1;
          failL  <= 1'b0;
        end
      end
    end

    assign tapOut[g*TAP_W +: TAP_W] = busy ? sweepTap : chosen;
    assign laneDone[g] = okL;
    assign laneFail[g] = failL;
  end

endmodule

// File: rtl/laneDelayCal.sv
module laneDelayCal
  import calib_pkg::*;
#(
  parameter int                 LANES      = 4,
  parameter int                 TAP_W      = 5,
  parameter int                 SAMPLES    = 256,
  parameter int                 SETTLE_CYC = 8,
  parameter int                 SYNC_GAP   = 4,
  parameter int                 PAT_LEN    = 8,
  parameter logic [PAT_LEN-1:0] PATTERN    = 8'hB4,
  parameter int                 HUNT_MAX   = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [LANES-1:0]       laneBits,
  output logic                   busy,
  output logic                   senderReset,
  output logic [LANES*TAP_W-1:0] tapOut,
  output logic [LANES-1:0]       laneDone,
  output logic [LANES-1:0]       laneFail
);

  localparam int MEAS_LIMIT = HUNT_MAX + SYNC_GAP + SAMPLES + 2;

  calStrobe_t       strobe;
  logic [TAP_W-1:0] sweepTap;
  logic             allMeasDone;

  calCtrl #(
    .TAP_W(TAP_W), .SETTLE_CYC(SETTLE_CYC), .MEAS_LIMIT(MEAS_LIMIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .allMeasDone(allMeasDone),
    .strobe(strobe), .sweepTap(sweepTap), .busy(busy), .senderReset(senderReset)
  );

  calDatapath #(
    .LANES(LANES), .TAP_W(TAP_W), .SAMPLES(SAMPLES), .SYNC_GAP(SYNC_GAP),
    .PAT_LEN(PAT_LEN), .PATTERN(PATTERN)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sweepTap(sweepTap), .busy(busy),
    .laneBits(laneBits), .tapOut(tapOut), .laneDone(laneDone),
    .laneFail(laneFail), .allMeasDone(allMeasDone)
  );

endmodule

// File: rtl/laneDelayCalChk.sv
module laneDelayCalChk #(
  parameter int LANES      = 4,
  parameter int TAP_W      = 5,
  parameter int SETTLE_CYC = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   start,
  input logic                   busy,
  input logic                   senderReset,
  input logic [LANES*TAP_W-1:0] tapOut,
  input logic [LANES-1:0]       laneDone,
  input logic [LANES-1:0]       laneFail
);

  localparam int HW = $clog2(SETTLE_CYC + 2);

  logic [TAP_W-1:0] tap0, prevTap;
  logic [HW-1:0]    heldCnt;

  assign tap0 = tapOut[TAP_W-1:0];

  // cycles the lane-0 tap has stayed unchanged (saturating)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevTap <= '0;
      heldCnt <= '0;
    end else begin
      prevTap <= tap0;
      if (tap0 != prevTap)                heldCnt <= '0;
      else if (heldCnt != HW'(SETTLE_CYC)) heldCnt <= heldCnt + 1'b1;
    end
  end

  // R2
  start_to_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R2
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && tap0 != $past(tap0)) |-> tap0 == $past(tap0) + 1'b1);

  // R3
  settle_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    senderReset |-> heldCnt >= HW'(SETTLE_CYC - 1));

  // R4
  kick_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    senderReset |=> !senderReset);

  // R7
  fail_tap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && laneFail[0]) |-> tap0 == '0);

  // R8
  status_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (laneDone & laneFail) == '0);

  // R8
  all_resolved_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (laneDone | laneFail) == {LANES{1'b1}});

endmodule

bind laneDelayCal laneDelayCalChk #(
  .LANES(LANES), .TAP_W(TAP_W), .SETTLE_CYC(SETTLE_CYC)
) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .senderReset(senderReset),
  .tapOut(tapOut), .laneDone(laneDone), .laneFail(laneFail)
);

// File: tb/tb_laneDelayCal.sv
module tb_laneDelayCal;

  localparam int LANES = 4;
  localparam int TAP_W = 5;
  localparam int NTAPS = 32;
  localparam int SETTLE = 8;
  localparam int GAP = 4;
  localparam logic [7:0] PAT = 8'hB4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LANES-1:0] laneBits = '0;
  logic busy, senderReset;
  logic [LANES*TAP_W-1:0] tapOut;
  logic [LANES-1:0] laneDone, laneFail;

  always #2 clk = ~clk;  // 250 MHz

  laneDelayCal dut (
    .clk(clk), .rstN(rstN), .start(start), .laneBits(laneBits), .busy(busy),
    .senderReset(senderReset), .tapOut(tapOut), .laneDone(laneDone), .laneFail(laneFail)
  );

  int checks = 0;
  int fails  = 0;

  // delay-line and sender model
  logic [NTAPS-1:0] mask [LANES];
  int  dly  [LANES];
  bit  dead [LANES];
  bit  seqActive = 0;
  int  pos = 0;

  // monitor state for R3/R4
  int  pulses = 0, wideErr = 0, settleErr = 0, held = 0;
  logic [TAP_W-1:0] prevTapTb = '0;
  bit  prevKick = 0;

  function automatic logic idealBit(int p, int d);
    if (p < d) return 1'b0;
    if (p == d) return 1'b1;
    if (p <= d + GAP) return 1'b0;
    return PAT[(p - d - GAP - 1) % 8];
  endfunction

  // expected chosen tap; -1 means the lane fails
  function automatic int expTap(logic [NTAPS-1:0] m, bit isDead);
    int bs = 0, bl = 0, cs = 0, cl = 0;
    if (isDead) return -1;
    for (int t = 0; t < NTAPS; t++) begin
      if (m[t]) begin
        if (cl == 0) cs = t;
        cl++;
        if (cl > bl) begin bl = cl; bs = cs; end
      end else cl = 0;
    end
    if (bl == 0) return -1;
    return bs + (bl - 1) / 2;
  endfunction

  always @(negedge clk) begin
    logic [TAP_W-1:0] t0;
    if (senderReset) begin seqActive = 1; pos = 0; end
    else if (seqActive) pos++;
    for (int l = 0; l < LANES; l++) begin
      logic [TAP_W-1:0] tp;
      tp = tapOut[l*TAP_W +: TAP_W];
      if (dead[l] || !seqActive) laneBits[l] = 1'b0;
      else if (!mask[l][tp])     laneBits[l] = 1'($urandom & 1);
      else                       laneBits[l] = idealBit(pos, dly[l]);
    end
    t0 = tapOut[TAP_W-1:0];
    if (t0 != prevTapTb) held = 1; else held++;
    prevTapTb = t0;
    if (senderReset) begin
      pulses++;
      if (prevKick) wideErr++;
      if (held < SETTLE + 1) settleErr++;
    end
    prevKick = senderReset;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runCal(bit midStart);
    pulses = 0; wideErr = 0; settleErr = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
    check(tapOut[TAP_W-1:0] == 0, "R2", "first sweep tap", int'(tapOut[TAP_W-1:0]), 0);
    if (midStart) begin
      while (tapOut[TAP_W-1:0] < 10) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      @(negedge clk);
      check(busy && tapOut[TAP_W-1:0] >= 10, "R9", "sweep tap after start while busy",
            int'(tapOut[TAP_W-1:0]), 10);
    end
    while (busy) @(negedge clk);
    check(pulses == NTAPS && wideErr == 0, "R4", "training pulses per sweep", pulses, NTAPS);
    check(settleErr == 0, "R3", "pulses issued before settle", settleErr, 0);
    for (int l = 0; l < LANES; l++) begin
      int e = expTap(mask[l], dead[l]);
      int a = int'(tapOut[l*TAP_W +: TAP_W]);
      if (e < 0) begin
        check(laneFail[l] && !laneDone[l], "R7", $sformatf("lane %0d fail flag", l),
              int'(laneFail[l]), 1);
        check(a == 0, "R7", $sformatf("lane %0d failed tap", l), a, 0);
      end else begin
        check(laneDone[l] && !laneFail[l], "R8", $sformatf("lane %0d done flag", l),
              int'(laneDone[l]), 1);
        check(a == e, "R6", $sformatf("lane %0d centred tap", l), a, e);
      end
    end
  endtask

  function automatic logic [NTAPS-1:0] window(int lo, int hi);
    logic [NTAPS-1:0] m = '0;
    for (int t = lo; t <= hi && t < NTAPS; t++) m[t] = 1'b1;
    return m;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < LANES; l++) begin mask[l] = '0; dly[l] = 1; dead[l] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && senderReset === 1'b0, "R1", "idle outputs", int'(busy), 0);
    check(laneDone === '0 && laneFail === '0, "R1", "status flags", int'(laneDone), 0);
    check(tapOut === '0, "R1", "taps", int'(tapOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed: interior window, low edge, longer late run, empty (R5, R6, R7)
    mask[0] = window(10, 25);             dly[0] = 1;
    mask[1] = window(0, 5);               dly[1] = 3;
    mask[2] = window(3, 6) | window(20, 31); dly[2] = 5;
    mask[3] = '0;                         dly[3] = 2;
    runCal(0);

    // directed: full range, tie, single top tap, silent lane (R5 sync timeout), R9
    mask[0] = '1;                         dly[0] = 2;
    mask[1] = window(2, 5) | window(12, 15); dly[1] = 1;
    mask[2] = window(31, 31);             dly[2] = 6;
    mask[3] = '1;                         dead[3] = 1;
    runCal(1);
    dead[3] = 0;

    // seeded random windows
    for (int r = 0; r < 4; r++) begin
      for (int l = 0; l < LANES; l++) begin
        int k = int'($urandom % 8);
        dly[l] = 1 + int'($urandom % 6);
        if (k == 0) mask[l] = '0;
        else begin
          int lo = int'($urandom % 32);
          mask[l] = window(lo, lo + int'($urandom % 20));
          if (k > 4) begin
            lo = int'($urandom % 32);
            mask[l] |= window(lo, lo + int'($urandom % 12));
          end
        end
      end
      runCal(0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule